// File: doc/BRIEF.md
# Framed Serial Control Register Writer

This block loads a six-bit control word from a three-wire serial port into a control register that lives in the system clock domain. An external host drives a serial clock, a serial data line and an active-low frame signal. While the frame is low, the block takes one data bit on each falling edge of the serial clock. When the sixth bit arrives, all six bits move into the register together. After that, more serial clock edges in the same frame have no effect.

A frame that goes high again before six bits have arrived is thrown away. The register keeps its old value, and the block raises a one-cycle short-frame strobe. The register holds a data format bit, a standby bit, a software conversion start bit and a three-bit channel address. The block also gives the selected channel number, which runs from 1 to 8. The host clock and frame lines are slow next to the system clock. They are brought across with a synchronizer chain of `SYNC_STAGES` flops and handled as sampled levels.

Top module: `ser_ctrl_writer`

## Requirements
- R1: After reset the format, standby and conversion bits are 0, the address is 0, the channel is 1, and both strobes are low.
- R2: Bits are taken on falling serial clock edges while the frame is low. Serial bit number i, counting from 0, sets word bit i. The word bits are: bit 0 format, bit 1 standby, bit 2 conversion start, bits 3, 4 and 5 address bits 0, 1 and 2.
- R3: The register does not change after the first five edges of a frame. All six bits load together on the sixth edge.
- R4: Falling edges after the sixth in the same frame change neither the register nor the strobes.
- R5: If the frame rises with fewer than six edges taken, including zero, the register is left unchanged and the short-frame strobe is high for exactly one cycle.
- R6: Each completed frame gives exactly one write-done pulse of one cycle. The two strobes are never high together.
- R7: The channel output equals the address plus 1, so it runs from 1 to 8.
- R8: The bit count clears while the frame is high. A full frame that follows an aborted one loads only its own six bits.
- R9: A register update or strobe appears exactly `SYNC_STAGES` system clock cycles after the first system clock edge that samples the input change causing it.
- R10: Falling serial clock edges while the frame is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Host serial clock, asynchronous |
| frame_n_i | input | 1 | Active-low write frame, asynchronous |
| ser_din_i | input | 1 | Serial data, taken on falling serial clock edges |
| fmt_o | output | 1 | Data format bit (word bit 0) |
| standby_o | output | 1 | Standby bit (word bit 1) |
| sw_conv_o | output | 1 | Software conversion start bit (word bit 2) |
| addr_o | output | 3 | Channel address (word bits 5:3) |
| channel_o | output | 4 | Selected channel, address plus 1 |
| write_done_o | output | 1 | One-cycle pulse when a six-bit word is loaded |
| short_frame_o | output | 1 | One-cycle pulse when a frame ends early |

## Verification
A wrong bit count or a wrong shift position shows at the ports in three ways. The register loads at the wrong edge, the fields are permuted, or late bits leak in. The change becomes visible `SYNC_STAGES` cycles after the edge that caused it. A count that does not clear between frames shows as a lost or early load, or as a wrong short-frame strobe, at the next frame boundary. The bench checks every output on every clock against a delayed behavioural model, so any such error is reported in the first cycle it appears.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;

  localparam int unsigned WORD_BITS = 6;
  localparam int unsigned ADDR_BITS = 3;
  localparam int unsigned CNT_BITS  = $clog2(WORD_BITS + 1);
  localparam int unsigned CHAN_BITS = ADDR_BITS + 1;

  // Packed so that serial bit i lands at word bit i.
  typedef struct packed {
    logic [ADDR_BITS-1:0] addr;
    logic                 sw_conv;
    logic                 standby;
    logic                 fmt;
  } ctrl_word_t;

  // Positions of the three input lines inside the synchronizer bus.
  localparam int unsigned LN_DIN   = 0;
  localparam int unsigned LN_FRAME = 1;
  localparam int unsigned LN_SCLK  = 2;
  localparam int unsigned LINES    = 3;

endpackage

// File: rtl/ser_ctrl_sync.sv
module ser_ctrl_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar b, s;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_line
      logic [STAGES-1:0] chain_q;
      for (s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= IDLE[b];
            else     chain_q[0] <= async_i[b];
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= IDLE[b];
            else     chain_q[s] <= chain_q[s-1];
          end
        end
      end
      assign sync_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ser_ctrl_rx.sv
module ser_ctrl_rx
  import ser_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_i,
  input  logic       frame_n_i,
  input  logic       din_i,
  output logic       commit_o,
  output ctrl_word_t word_o,
  output logic       abort_o
);

  logic                 sclk_prev_q;
  logic                 frame_prev_q;
  logic [CNT_BITS-1:0]  cnt_q;
  logic [WORD_BITS-1:0] shift_q;
  logic                 fall;
  logic                 rise;
  logic                 take;
  logic                 full;

  localparam logic [CNT_BITS-1:0] LAST = CNT_BITS'(WORD_BITS - 1);
  localparam logic [CNT_BITS-1:0] DONE = CNT_BITS'(WORD_BITS);

  assign fall = sclk_prev_q & ~sclk_i;
  assign rise = ~frame_prev_q & frame_n_i;
  assign full = (cnt_q == DONE);
  assign take = ~frame_n_i & fall & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q  <= 1'b1;
      frame_prev_q <= 1'b1;
    end else begin
      sclk_prev_q  <= sclk_i;
      frame_prev_q <= frame_n_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (frame_n_i) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q   <= cnt_q + 1'b1;
      shift_q <= {din_i, shift_q[WORD_BITS-1:1]};
    end
  end

  assign commit_o = take & (cnt_q == LAST);
  assign word_o   = ctrl_word_t'({din_i, shift_q[WORD_BITS-1:1]});
  assign abort_o  = rise & ~full;

endmodule

// File: rtl/ser_ctrl_regs.sv
module ser_ctrl_regs
  import ser_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit_i,
  input  ctrl_word_t           word_i,
  input  logic                 abort_i,
  output ctrl_word_t           ctrl_o,
  output logic [CHAN_BITS-1:0] chan_o,
  output logic                 done_o,
  output logic                 short_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      chan_o <= CHAN_BITS'(1);
    end else if (commit_i) begin
      ctrl_o <= word_i;
      chan_o <= {1'b0, word_i.addr} + CHAN_BITS'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o  <= 1'b0;
      short_o <= 1'b0;
    end else begin
      done_o  <= commit_i;
      short_o <= abort_i;
    end
  end

endmodule

// File: rtl/ser_ctrl_writer.sv
module ser_ctrl_writer
  import ser_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_clk_i,
  input  logic                 frame_n_i,
  input  logic                 ser_din_i,
  output logic                 fmt_o,
  output logic                 standby_o,
  output logic                 sw_conv_o,
  output logic [ADDR_BITS-1:0] addr_o,
  output logic [CHAN_BITS-1:0] channel_o,
  output logic                 write_done_o,
  output logic                 short_frame_o
);

  localparam logic [LINES-1:0] IDLE_LEVELS =
    (LINES'(1) << LN_SCLK) | (LINES'(1) << LN_FRAME);

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  logic             commit;
  logic             abort;
  ctrl_word_t       new_word;
  ctrl_word_t       ctrl_q;

  always_comb begin
    raw_lines           = '0;
    raw_lines[LN_SCLK]  = ser_clk_i;
    raw_lines[LN_FRAME] = frame_n_i;
    raw_lines[LN_DIN]   = ser_din_i;
  end

  ser_ctrl_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINES),
    .IDLE   (IDLE_LEVELS)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  ser_ctrl_rx u_rx (
    .clk       (clk),
    .rst       (rst),
    .sclk_i    (sync_lines[LN_SCLK]),
    .frame_n_i (sync_lines[LN_FRAME]),
    .din_i     (sync_lines[LN_DIN]),
    .commit_o  (commit),
    .word_o    (new_word),
    .abort_o   (abort)
  );

  ser_ctrl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .word_i   (new_word),
    .abort_i  (abort),
    .ctrl_o   (ctrl_q),
    .chan_o   (channel_o),
    .done_o   (write_done_o),
    .short_o  (short_frame_o)
  );

  assign fmt_o     = ctrl_q.fmt;
  assign standby_o = ctrl_q.standby;
  assign sw_conv_o = ctrl_q.sw_conv;
  assign addr_o    = ctrl_q.addr;

endmodule

// File: rtl/ser_ctrl_writer_chk.sv
module ser_ctrl_writer_chk
  import ser_ctrl_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 fmt_o,
  input logic                 standby_o,
  input logic                 sw_conv_o,
  input logic [ADDR_BITS-1:0] addr_o,
  input logic [CHAN_BITS-1:0] channel_o,
  input logic                 write_done_o,
  input logic                 short_frame_o
);

  logic [WORD_BITS-1:0] word;
  assign word = {addr_o, sw_conv_o, standby_o, fmt_o};

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(write_done_o && short_frame_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    write_done_o |=> !write_done_o);

  assert_short_single_R5: assert property (@(posedge clk) disable iff (rst)
    short_frame_o |=> !short_frame_o);

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (rst)
    !write_done_o |-> $stable(word));

  assert_channel_map_R7: assert property (@(posedge clk) disable iff (rst)
    channel_o == ({1'b0, addr_o} + CHAN_BITS'(1)));

endmodule

bind ser_ctrl_writer ser_ctrl_writer_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .fmt_o         (fmt_o),
  .standby_o     (standby_o),
  .sw_conv_o     (sw_conv_o),
  .addr_o        (addr_o),
  .channel_o     (channel_o),
  .write_done_o  (write_done_o),
  .short_frame_o (short_frame_o)
);

// File: tb/tb_ser_ctrl_writer.sv
`timescale 1ns/1ps
module tb_ser_ctrl_writer;

  localparam int SYNC = 2;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic frame_n = 1'b1;
  logic din = 1'b0;
  logic       fmt, stby, conv, done, shortf;
  logic [2:0] addr;
  logic [3:0] chan;

  int checks = 0;
  int fails = 0;
  int n_done = 0;
  int n_short = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ser_ctrl_writer #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .frame_n_i(frame_n),
    .ser_din_i(din), .fmt_o(fmt), .standby_o(stby), .sw_conv_o(conv),
    .addr_o(addr), .channel_o(chan), .write_done_o(done),
    .short_frame_o(shortf)
  );

  // Behavioural reference: one entry per system clock, {done, short, word}.
  int m_cnt;
  bit m_prev_sclk, m_prev_fn;
  bit [5:0] m_bits, m_word;
  bit [7:0] pipe[$];

  always @(posedge clk) begin
    bit e_done, e_short;
    if (rst) begin
      m_cnt = 0; m_prev_sclk = 1; m_prev_fn = 1; m_word = 0; m_bits = 0;
      pipe.delete();
    end else begin
      e_done = 0; e_short = 0;
      if (frame_n) begin
        if (!m_prev_fn && m_cnt < 6) e_short = 1;
        m_cnt = 0;
      end else if (m_prev_sclk && !sclk && m_cnt < 6) begin
        m_bits[m_cnt] = din;
        m_cnt++;
        if (m_cnt == 6) begin m_word = m_bits; e_done = 1; end
      end
      m_prev_sclk = sclk; m_prev_fn = frame_n;
      pipe.push_back({e_done, e_short, m_word});
      if (pipe.size() > SYNC + 1) void'(pipe.pop_front());
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the model, SYNC cycles later (R9).
  always @(negedge clk) begin
    if (!rst) begin
      if (done) n_done++;
      if (shortf) n_short++;
      if (pipe.size() == SYNC + 1) begin
        check("R9", "word", {addr, conv, stby, fmt}, pipe[0][5:0]);
        check("R6", "write_done", done, pipe[0][7]);
        check("R5", "short_frame", shortf, pipe[0][6]);
        check("R7", "channel", chan, pipe[0][5:3] + 1);
      end
    end
  end

  task automatic ser_edges(input bit [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      din = bits[i];
      repeat (HALF) @(negedge clk);
      sclk = 0;
      repeat (HALF) @(negedge clk);
      sclk = 1;
    end
  endtask

  task automatic frame(input bit [15:0] bits, input int n);
    frame_n = 0;
    repeat (HALF) @(negedge clk);
    ser_edges(bits, n);
    repeat (HALF) @(negedge clk);
    frame_n = 1;
    repeat (HALF + SYNC + 4) @(negedge clk);
  endtask

  task automatic expect_word(string req, bit [5:0] w);
    check(req, "word", {addr, conv, stby, fmt}, w);
    check(req, "channel", chan, w[5:3] + 1);
  endtask

  initial begin
    int d0, s0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (6) @(negedge clk);
    // R1: reset state
    expect_word("R1", 6'h00);
    check("R1", "strobes", {done, shortf}, 0);

    // R2: field order, full frame
    d0 = n_done;
    frame(16'b101101, 6);
    expect_word("R2", 6'b101101);
    check("R6", "done pulses", n_done - d0, 1);

    // R3: no change after five edges, then load on the sixth
    frame_n = 0;
    repeat (HALF) @(negedge clk);
    ser_edges(16'b010010, 5);
    repeat (HALF + SYNC + 4) @(negedge clk);
    expect_word("R3", 6'b101101);
    ser_edges(16'b000001, 1);
    repeat (SYNC + 3) @(negedge clk);
    expect_word("R3", 6'b110010);
    frame_n = 1;
    repeat (HALF + SYNC + 4) @(negedge clk);

    // R4: extra edges in the same frame ignored
    d0 = n_done;
    frame(16'b1010_1010_1001_0110, 12);
    expect_word("R4", 6'b010110);
    check("R4", "done pulses", n_done - d0, 1);

    // R5: short frames, three edges and zero edges
    s0 = n_short; d0 = n_done;
    frame(16'b111111, 3);
    expect_word("R5", 6'b010110);
    check("R5", "short pulses", n_short - s0, 1);
    frame(16'b000000, 0);
    check("R5", "short pulses zero-edge", n_short - s0, 2);
    check("R5", "no done", n_done - d0, 0);

    // R8: full frame after abort loads only its own bits
    frame(16'b111111, 4);
    frame(16'b000011, 6);
    expect_word("R8", 6'b000011);

    // R10: falling edges with frame high have no effect
    s0 = n_short; d0 = n_done;
    ser_edges(16'b111111, 8);
    repeat (SYNC + 4) @(negedge clk);
    expect_word("R10", 6'b000011);
    check("R10", "strobes", (n_short - s0) + (n_done - d0), 0);

    // R7: all eight channels
    for (int a = 0; a < 8; a++) begin
      frame(16'((a << 3) | (a & 7)), 6);
      expect_word("R7", 6'((a << 3) | (a & 7)));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule